// File: doc/BRIEF.md
# Gate Driver Fault Shutdown Controller

This block sits between the three-phase PWM commands and the six gate-drive enables of an inverter bridge. It watches two fault flags, an overcurrent comparator trip and a control-supply undervoltage flag, and on either one it cuts the gate enables and drives an open-drain fault line low for a minimum hold time. That line is shared with the host, so the host and the board's RC network can also hold it low.

The shared pin comes in as two digitised views. One goes high while the pin voltage is below the unlatch threshold. The other goes high while the pin is above the logic-high threshold. An overcurrent cuts the gates combinationally in the cycle the trip is seen. The pull-down is released only after the hold time has elapsed and the pin has been seen discharged. Gates come back only once the pin has recovered above the logic-high threshold. An undervoltage fault holds the pull-down for its own longer minimum and for as long as the supply flag stays asserted.

Hold times are parameters in clock cycles. Their defaults are derived from a clock-frequency parameter: 20 µs for overcurrent and 50 µs for undervoltage. A two-bit status output reports the cause of the most recent shutdown.

Top module: `gate_fault_guard`

## Requirements
- R1: After reset all six gate enables are 0, `od_pull` is 0 and `fault_cause` is 0 (none). Gates stay 0 until `pin_above_high` has been sampled high at a clock edge.
- R2: In normal running, `gate_hi[i]` equals `pwm_hi[i]` and `gate_lo[i]` equals `pwm_lo[i]`. Both PWM inputs and both gate outputs are active-high, and bit i is phase i.
- R3: While `oc_trip` is 1, all six gate enables are 0 in that same cycle, with no register in the path.
- R4: A fault sampled at an edge sets `od_pull` to 1 after that edge. `fault_cause` then reads 1 for overcurrent or 2 for undervoltage, and 3 for an external pull-low.
- R5: An overcurrent keeps `od_pull` high for OC_HOLD_CYC cycles after the last edge at which `oc_trip` was sampled high, and never for fewer. A trip held for N edges gives N+OC_HOLD_CYC-1 cycles when the pin is already discharged.
- R6: After the overcurrent hold time has elapsed, `od_pull` stays high until `pin_below_unlatch` is sampled high, and is released at that edge.
- R7: An undervoltage keeps `od_pull` high for UV_HOLD_CYC cycles after the last edge with `uv_flag` high. Release does not wait for `pin_below_unlatch`.
- R8: After `od_pull` is released, gates stay 0 while `pin_above_high` is 0. At the first edge that samples it high, gates follow PWM again and `fault_cause` returns to 0.
- R9: In normal running, `pin_above_high` at 0 forces the gates to 0 in the same cycle. From the next edge `fault_cause` reads 3 and `od_pull` stays 0.
- R10: Any fault flag during a hold restarts the hold counter. An overcurrent during an undervoltage hold restarts the UV_HOLD_CYC window and leaves the cause at 2. An undervoltage during an overcurrent hold switches to the undervoltage hold.
- R11: While `uv_flag` is 1, all six gate enables are 0 in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwm_hi | input | PHASES | High-side PWM commands, active-high |
| pwm_lo | input | PHASES | Low-side PWM commands, active-high |
| oc_trip | input | 1 | Overcurrent comparator flag |
| uv_flag | input | 1 | Control supply below its turn-on threshold |
| pin_below_unlatch | input | 1 | Shutdown pin is below the unlatch threshold |
| pin_above_high | input | 1 | Shutdown pin is above the logic-high threshold |
| gate_hi | output | PHASES | High-side gate enables |
| gate_lo | output | PHASES | Low-side gate enables |
| od_pull | output | 1 | Open-drain pull-down of the shutdown pin is on |
| fault_cause | output | 2 | 0 none, 1 overcurrent, 2 undervoltage, 3 external |

## Verification
A state register stuck in the running state would show gates echoing PWM within one cycle of a trip being released while `od_pull` is still high, or with the pin still low. A hold counter that loads a wrong value, or fails to reload, changes the number of cycles `od_pull` stays high, so the length of each pulse is counted exactly. A release that ignores the unlatch view shows up as `od_pull` falling while that input is held low. A cause register that is not updated shows a wrong `fault_cause` value from the first cycle after the fault.

// File: rtl/gfg_pkg.sv
package gfg_pkg;

    typedef enum logic [1:0] {
        ST_RECOVER = 2'd0,
        ST_RUN     = 2'd1,
        ST_OC_HOLD = 2'd2,
        ST_UV_HOLD = 2'd3
    } guard_state_e;

    typedef enum logic [1:0] {
        CAUSE_NONE = 2'd0,
        CAUSE_OC   = 2'd1,
        CAUSE_UV   = 2'd2,
        CAUSE_EXT  = 2'd3
    } fault_cause_e;

    // Converts a duration in microseconds into clock cycles (at least one).
    function automatic int us_to_cycles(input int clk_khz, input int usec);
        int c;
        c = (clk_khz * usec) / 1000;
        return (c < 1) ? 1 : c;
    endfunction

endpackage

// File: rtl/gfg_hold_timer.sv
module gfg_hold_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          done
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign done = (cnt_q == '0);

    // R5: a running count advances by exactly one per cycle when not reloaded
    assert_count_step_R5: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

    // R10: a reload always takes effect on the next cycle
    assert_reload_R10: assert property (@(posedge clk) disable iff (rst)
        load |=> (cnt_q == $past(load_val)));
endmodule

// File: rtl/gfg_gate_mask.sv
module gfg_gate_mask #(
    parameter int PHASES = 3
) (
    input  logic              en,
    input  logic [PHASES-1:0] pwm_hi,
    input  logic [PHASES-1:0] pwm_lo,
    output logic [PHASES-1:0] gate_hi,
    output logic [PHASES-1:0] gate_lo
);
    for (genvar p = 0; p < PHASES; p++) begin : g_phase
        assign gate_hi[p] = en & pwm_hi[p];
        assign gate_lo[p] = en & pwm_lo[p];
    end
endmodule

// File: rtl/gate_fault_guard.sv
module gate_fault_guard #(
    parameter int PHASES      = 3,
    parameter int CLK_KHZ     = 100000,
    parameter int OC_HOLD_CYC = gfg_pkg::us_to_cycles(CLK_KHZ, 20),
    parameter int UV_HOLD_CYC = gfg_pkg::us_to_cycles(CLK_KHZ, 50)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PHASES-1:0] pwm_hi,
    input  logic [PHASES-1:0] pwm_lo,
    input  logic              oc_trip,
    input  logic              uv_flag,
    input  logic              pin_below_unlatch,
    input  logic              pin_above_high,
    output logic [PHASES-1:0] gate_hi,
    output logic [PHASES-1:0] gate_lo,
    output logic              od_pull,
    output logic [1:0]        fault_cause
);
    import gfg_pkg::*;

    localparam int MAX_HOLD = (UV_HOLD_CYC > OC_HOLD_CYC) ? UV_HOLD_CYC : OC_HOLD_CYC;
    localparam int CW       = $clog2(MAX_HOLD + 1);
    localparam logic [CW-1:0] OC_RELOAD = CW'(OC_HOLD_CYC - 1);
    localparam logic [CW-1:0] UV_RELOAD = CW'(UV_HOLD_CYC - 1);

    guard_state_e  state_q, state_nx;
    fault_cause_e  cause_q, cause_nx;
    logic          tmr_load;
    logic [CW-1:0] tmr_val;
    logic          tmr_done;
    logic          gate_en;

    always_comb begin
        state_nx = state_q;
        cause_nx = cause_q;
        tmr_load = 1'b0;
        tmr_val  = OC_RELOAD;
        unique case (state_q)
            ST_RECOVER, ST_RUN: begin
                if (uv_flag) begin
                    state_nx = ST_UV_HOLD;
                    cause_nx = CAUSE_UV;
                    tmr_load = 1'b1;
                    tmr_val  = UV_RELOAD;
                end else if (oc_trip) begin
                    state_nx = ST_OC_HOLD;
                    cause_nx = CAUSE_OC;
                    tmr_load = 1'b1;
                end else if (state_q == ST_RECOVER && pin_above_high) begin
                    state_nx = ST_RUN;
                    cause_nx = CAUSE_NONE;
                end else if (state_q == ST_RUN && !pin_above_high) begin
                    state_nx = ST_RECOVER;
                    cause_nx = CAUSE_EXT;
                end
            end
            ST_OC_HOLD: begin
                if (uv_flag) begin
                    state_nx = ST_UV_HOLD;
                    cause_nx = CAUSE_UV;
                    tmr_load = 1'b1;
                    tmr_val  = UV_RELOAD;
                end else if (oc_trip) begin
                    tmr_load = 1'b1;
                end else if (tmr_done && pin_below_unlatch) begin
                    state_nx = ST_RECOVER;
                end
            end
            ST_UV_HOLD: begin
                if (uv_flag || oc_trip) begin
                    tmr_load = 1'b1;
                    tmr_val  = UV_RELOAD;
                end else if (tmr_done) begin
                    state_nx = ST_RECOVER;
                end
            end
            default: state_nx = ST_RECOVER;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_RECOVER;
            cause_q <= CAUSE_NONE;
        end else begin
            state_q <= state_nx;
            cause_q <= cause_nx;
        end
    end

    gfg_hold_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    // Direct cut: the fault flags and the pin view gate the enables without a register.
    assign gate_en = (state_q == ST_RUN) & ~oc_trip & ~uv_flag & pin_above_high;

    gfg_gate_mask #(.PHASES(PHASES)) u_mask (
        .en      (gate_en),
        .pwm_hi  (pwm_hi),
        .pwm_lo  (pwm_lo),
        .gate_hi (gate_hi),
        .gate_lo (gate_lo)
    );

    assign od_pull     = (state_q == ST_OC_HOLD) || (state_q == ST_UV_HOLD);
    assign fault_cause = cause_q;

    // R1: the first cycle after reset has the pull-down off and the gates off
    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!od_pull && gate_hi == '0 && gate_lo == '0));

    // R3: an overcurrent trip leaves no gate enabled
    assert_trip_cuts_gates_R3: assert property (@(posedge clk) disable iff (rst)
        oc_trip |-> (gate_hi == '0 && gate_lo == '0));

    // R11: undervoltage leaves no gate enabled
    assert_uv_cuts_gates_R11: assert property (@(posedge clk) disable iff (rst)
        uv_flag |-> (gate_hi == '0 && gate_lo == '0));

    // R4: a fault sampled outside a hold turns the pull-down on at the next edge
    assert_fault_pulls_R4: assert property (@(posedge clk) disable iff (rst)
        (!od_pull && (oc_trip || uv_flag)) |=> od_pull);

    // R6: an overcurrent hold ends only with the pin seen below the unlatch level
    assert_release_unlatch_R6: assert property (@(posedge clk) disable iff (rst)
        ($fell(od_pull) && $past(cause_q == CAUSE_OC)) |-> $past(pin_below_unlatch));

    // R8: no gate is enabled while the pin is not above the logic-high level
    assert_wait_high_R8: assert property (@(posedge clk) disable iff (rst)
        !pin_above_high |-> (gate_hi == '0 && gate_lo == '0));

    // R9: an external pull-low never turns on the block's own pull-down
    assert_ext_no_pull_R9: assert property (@(posedge clk) disable iff (rst)
        (cause_q == CAUSE_EXT) |-> !od_pull);
endmodule

// File: tb/gate_fault_guard_tb.sv
module gate_fault_guard_tb;
    localparam int PERIOD = 10;
    localparam int PH     = 3;
    localparam int OC_CYC = 8;
    localparam int UV_CYC = 20;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [PH-1:0] pwm_hi = '0, pwm_lo = '0;
    logic          oc_trip = 1'b0, uv_flag = 1'b0;
    logic          pin_below_unlatch = 1'b1, pin_above_high = 1'b0;
    logic [PH-1:0] gate_hi, gate_lo;
    logic          od_pull;
    logic [1:0]    fault_cause;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    gate_fault_guard #(.PHASES(PH), .OC_HOLD_CYC(OC_CYC), .UV_HOLD_CYC(UV_CYC)) u_dut (
        .clk(clk), .rst(rst), .pwm_hi(pwm_hi), .pwm_lo(pwm_lo),
        .oc_trip(oc_trip), .uv_flag(uv_flag),
        .pin_below_unlatch(pin_below_unlatch), .pin_above_high(pin_above_high),
        .gate_hi(gate_hi), .gate_lo(gate_lo), .od_pull(od_pull), .fault_cause(fault_cause)
    );

    // PWM patterns {hi, lo} walked in normal running (R2)
    localparam logic [5:0] PWM_TAB [8] = '{6'b000_000, 6'b001_110, 6'b010_101, 6'b100_011,
                                           6'b111_000, 6'b000_111, 6'b101_010, 6'b110_001};

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    function automatic int gates();
        return {gate_hi, gate_lo};
    endfunction

    // Drives one fault flag for n edges, then counts cycles until od_pull falls.
    task automatic fault_pulse(input bit is_uv, input int n, output int cnt);
        cnt = 0;
        if (is_uv) uv_flag = 1'b1; else oc_trip = 1'b1;
        for (int k = 0; k < n; k++) begin
            step();
            if (od_pull) cnt++;
        end
        uv_flag = 1'b0;
        oc_trip = 1'b0;
        for (int g = 0; g < 200 && od_pull; g++) begin
            step();
            if (od_pull) cnt++;
        end
    endtask

    task automatic back_to_run();
        pin_below_unlatch = 1'b0;
        pin_above_high    = 1'b1;
        step();
    endtask

    initial begin
        int cnt;
        pwm_hi = 3'b111;
        pwm_lo = 3'b111;
        repeat (3) step();
        rst = 1'b0;
        #1;
        check("R1 gates after reset", gates(), 0);
        check("R1 od after reset", od_pull, 0);
        check("R1 cause after reset", fault_cause, 0);
        repeat (4) step();
        check("R1 gates before pin high", gates(), 0);

        back_to_run();
        check("R1 gates follow once pin high", gates(), 6'b111_111);

        // R2: table walk
        for (int i = 0; i < 8; i++) begin
            {pwm_hi, pwm_lo} = PWM_TAB[i];
            #1;
            check("R2 gates follow pwm", gates(), PWM_TAB[i]);
            step();
            check("R2 gates follow pwm after edge", gates(), PWM_TAB[i]);
        end

        // R3/R4/R6: trip with the pin not yet discharged
        pwm_hi = 3'b111; pwm_lo = 3'b111;
        oc_trip = 1'b1;
        #1;
        check("R3 same-cycle cut", gates(), 0);
        step();
        oc_trip = 1'b0;
        check("R4 od after trip", od_pull, 1);
        check("R4 cause overcurrent", fault_cause, 1);
        pin_above_high = 1'b0;
        repeat (OC_CYC + 4) step();
        check("R6 held while not unlatched", od_pull, 1);
        pin_below_unlatch = 1'b1;
        step();
        check("R6 released once unlatched", od_pull, 0);
        repeat (3) step();
        check("R8 gates off while pin low", gates(), 0);
        check("R8 cause kept", fault_cause, 1);
        pin_above_high = 1'b1;
        pin_below_unlatch = 1'b0;
        step();
        check("R8 gates resume", gates(), 6'b111_111);
        check("R8 cause cleared", fault_cause, 0);

        // R5: exact hold lengths with the pin already discharged
        pin_below_unlatch = 1'b1; pin_above_high = 1'b0;
        fault_pulse(1'b0, 1, cnt);
        check("R5 single trip hold", cnt, OC_CYC);
        back_to_run();
        pin_below_unlatch = 1'b1; pin_above_high = 1'b0;
        fault_pulse(1'b0, 3, cnt);
        check("R5 long trip hold", cnt, 3 + OC_CYC - 1);
        back_to_run();

        // R7/R11: undervoltage, pin never discharged
        uv_flag = 1'b1;
        #1;
        check("R11 same-cycle cut", gates(), 0);
        uv_flag = 1'b0;
        fault_pulse(1'b1, 5, cnt);
        check("R7 uv hold ignores pin", cnt, 5 + UV_CYC - 1);
        check("R4 cause undervoltage", fault_cause, 2);
        step();
        check("R8 back to run after uv", gates(), 6'b111_111);

        // R10: overcurrent inside an undervoltage hold restarts the window
        cnt = 0;
        uv_flag = 1'b1;
        step();
        if (od_pull) cnt++;
        uv_flag = 1'b0;
        for (int k = 1; k < 200 && od_pull; k++) begin
            oc_trip = (k == 10);
            step();
            if (od_pull) cnt++;
            if (k == 12) check("R10 cause stays uv", fault_cause, 2);
        end
        oc_trip = 1'b0;
        check("R10 uv window restarted", cnt, 10 + UV_CYC);
        back_to_run();

        // R10: undervoltage inside an overcurrent hold switches the hold
        cnt = 0;
        oc_trip = 1'b1;
        step();
        if (od_pull) cnt++;
        oc_trip = 1'b0;
        for (int k = 1; k < 200 && od_pull; k++) begin
            uv_flag = (k == 3);
            step();
            if (od_pull) cnt++;
            if (k == 3) check("R10 cause switches to uv", fault_cause, 2);
        end
        uv_flag = 1'b0;
        check("R10 uv hold after oc", cnt, 3 + UV_CYC);
        back_to_run();

        // R9: external pull-low while running
        pin_above_high = 1'b0;
        #1;
        check("R9 same-cycle cut", gates(), 0);
        step();
        check("R9 cause external", fault_cause, 3);
        check("R9 no own pull", od_pull, 0);
        pin_above_high = 1'b1;
        step();
        check("R9 gates resume", gates(), 6'b111_111);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(PERIOD * 100000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end
endmodule